// File: doc/BRIEF.md
# Programmable Trigger Delay Block

The block watches one trigger chosen from eight sources and, a programmed number of clock cycles after that trigger rises, produces delayed pulses on two independent output channels. Each channel has an early pulse (pre-trigger) and a main pulse (trigger). One channel would start the first converter and first amplifier, and the other would start the second pair. Both channels are timed from one shared run counter. Each channel keeps its own pair of delay values and its own enable.

Software configures the block through a simple write port. Address 0 is the control word. Addresses 1 and 2 hold the pre-trigger and trigger delays of channel A. Addresses 3 and 4 hold the same two delays for channel B. One of the eight source slots is a software trigger: writing the control word with its trigger bit set raises that slot for one cycle.

Top module: `trig_dly_top`

## Requirements
- R1: Control field bits [6:4] select the source index. Index i uses src_trig[i], except that index 2 is the software trigger. Rising edges on sources that are not selected start nothing.
- R2: Only a rising edge of the selected source starts a sequence. Holding the source high produces exactly one pulse per output.
- R3: Let E0 be the rising clock edge at which the selected source is first seen high. Each pre-trigger output is high for exactly one cycle, the cycle after clock edge E0+D, where D is that channel's pre-trigger delay (address 1 for A, 3 for B). D = 0 gives a pulse in the cycle right after E0.
- R4: Each trigger output pulses once with the same timing rule, using the trigger delay (address 2 for A, 4 for B). If the trigger delay is smaller than the pre-trigger delay, the trigger pulses in the same cycle as the pre-trigger.
- R5: The delays of channel A and channel B are independent of each other.
- R6: A rising edge that arrives while a sequence is running is ignored. The sequence ends once the largest effective delay of all channels has been reached, and a later edge then starts a new sequence.
- R7: Control bit 0 is the global enable. Clearing it aborts a running sequence and keeps all four outputs low. Setting it again does not restart a sequence until a new edge arrives.
- R8: Writing address 0 with bit 8 set produces a one-cycle pulse on source index 2, starting one cycle after the write. The pin src_trig[2] is ignored.
- R9: Control bits 1 and 2 enable the outputs of channel A and channel B. A disabled channel produces no pulses, and its delay values still count toward the length of the shared sequence.
- R10: After reset every register reads as zero, so the global enable is off and all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_trig | input | 8 | Hardware trigger sources, one per index |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | DLY_W | Register write data |
| pre_a | output | 1 | Channel A pre-trigger pulse |
| trig_a | output | 1 | Channel A trigger pulse |
| pre_b | output | 1 | Channel B pre-trigger pulse |
| trig_b | output | 1 | Channel B trigger pulse |

## Verification
A source edge is recognised at the first clock edge that samples it (E0). An output with delay D is then high in sample k = D, where sample k is taken at the falling edge that follows clock edge E0+k. A software trigger reaches E0 exactly one clock after the write has been captured. The bench counts samples from E0 in every window and checks two things for each output: the number of pulses, and the index of the first pulse. Each window runs past the end of the sequence, so a late pulse or an extra pulse shows up in the count.

// File: rtl/trig_dly_pkg.sv
package trig_dly_pkg;
  localparam int NUM_SRC  = 8;
  localparam int SEL_W    = $clog2(NUM_SRC);
  localparam int NUM_CH   = 2;
  localparam int ADDR_W   = 3;
  localparam int SRC_SW   = 2;
  localparam int CTL_EN   = 0;
  localparam int CTL_CH0  = 1;
  localparam int CTL_SEL0 = 4;
  localparam int CTL_SW   = 8;

  typedef enum logic [ADDR_W-1:0] {
    ADDR_CTRL = 3'd0,
    ADDR_APRE = 3'd1,
    ADDR_ATRG = 3'd2,
    ADDR_BPRE = 3'd3,
    ADDR_BTRG = 3'd4
  } reg_addr_e;
endpackage

// File: rtl/trig_dly_regs.sv
module trig_dly_regs
  import trig_dly_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [ADDR_W-1:0]          wr_addr,
  input  logic [DW-1:0]              wr_data,
  output logic                       glob_en,
  output logic [NUM_CH-1:0]          ch_en,
  output logic [SEL_W-1:0]           src_sel,
  output logic                       sw_pulse,
  output logic [NUM_CH-1:0][DW-1:0]  pre_dly,
  output logic [NUM_CH-1:0][DW-1:0]  trg_dly
);
  logic                      glob_en_d;
  logic [NUM_CH-1:0]         ch_en_d;
  logic [SEL_W-1:0]          src_sel_d;
  logic                      sw_pulse_d;
  logic [NUM_CH-1:0][DW-1:0] pre_dly_d;
  logic [NUM_CH-1:0][DW-1:0] trg_dly_d;

  always_comb begin
    glob_en_d  = glob_en;
    ch_en_d    = ch_en;
    src_sel_d  = src_sel;
    sw_pulse_d = 1'b0;
    pre_dly_d  = pre_dly;
    trg_dly_d  = trg_dly;
    if (wr_en) begin
      if (wr_addr == ADDR_CTRL) begin
        glob_en_d  = wr_data[CTL_EN];
        ch_en_d    = wr_data[CTL_CH0 +: NUM_CH];
        src_sel_d  = wr_data[CTL_SEL0 +: SEL_W];
        sw_pulse_d = wr_data[CTL_SW];
      end
      for (int c = 0; c < NUM_CH; c++) begin
        if (wr_addr == ADDR_W'(1 + 2 * c)) pre_dly_d[c] = wr_data;
        if (wr_addr == ADDR_W'(2 + 2 * c)) trg_dly_d[c] = wr_data;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      glob_en  <= 1'b0;
      ch_en    <= '0;
      src_sel  <= '0;
      sw_pulse <= 1'b0;
      pre_dly  <= '0;
      trg_dly  <= '0;
    end else begin
      glob_en  <= glob_en_d;
      ch_en    <= ch_en_d;
      src_sel  <= src_sel_d;
      sw_pulse <= sw_pulse_d;
      pre_dly  <= pre_dly_d;
      trg_dly  <= trg_dly_d;
    end
  end

  // R8: the software pulse only follows a register write
  assert_sw_from_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sw_pulse |-> $past(wr_en));
endmodule

// File: rtl/trig_dly_src.sv
module trig_dly_src
  import trig_dly_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_trig,
  input  logic               sw_pulse,
  input  logic [SEL_W-1:0]   src_sel,
  output logic               start_edge
);
  logic [NUM_SRC-1:0] src_vec;
  logic               sel_lvl;
  logic               sel_prev;

  always_comb begin
    src_vec         = src_trig;
    src_vec[SRC_SW] = sw_pulse;
  end

  assign sel_lvl    = src_vec[src_sel];
  assign start_edge = sel_lvl & ~sel_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel_prev <= 1'b0;
    else        sel_prev <= sel_lvl;
  end

  // R2: a detected edge is never seen two cycles running
  assert_edge_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start_edge |=> !start_edge);
endmodule

// File: rtl/trig_dly_seq.sv
module trig_dly_seq #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         glob_en,
  input  logic         start,
  input  logic [W-1:0] end_val,
  output logic         running,
  output logic [W-1:0] cnt
);
  logic         run_d;
  logic [W-1:0] cnt_d;
  logic         cnt_ce;

  always_comb begin
    run_d  = running;
    cnt_d  = cnt;
    cnt_ce = 1'b0;
    if (!glob_en) begin
      run_d  = 1'b0;
      cnt_d  = '0;
      cnt_ce = 1'b1;
    end else if (running) begin
      if (cnt >= end_val) begin
        run_d = 1'b0;
      end else begin
        cnt_d  = cnt + W'(1);
        cnt_ce = 1'b1;
      end
    end else if (start) begin
      run_d  = 1'b1;
      cnt_d  = '0;
      cnt_ce = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      cnt     <= '0;
    end else begin
      running <= run_d;
      if (cnt_ce) cnt <= cnt_d;
    end
  end

  // R7: clearing the global enable stops the sequence
  assert_abort_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !glob_en |=> !running);

  // R6: an edge during a run does not restart the count
  assert_ignore_edge_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (running && start && glob_en && (cnt < end_val)) |=> (running && (cnt == $past(cnt) + W'(1))));

  // R6: the run ends once the last delay has been reached
  assert_seq_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (running && (cnt >= end_val)) |=> !running);
endmodule

// File: rtl/trig_dly_chan.sv
module trig_dly_chan #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         running,
  input  logic [W-1:0] cnt,
  input  logic [W-1:0] pre_dly,
  input  logic [W-1:0] trg_dly,
  input  logic         glob_en,
  input  logic         ch_en,
  output logic         pre_o,
  output logic         trg_o,
  output logic [W-1:0] eff_trg
);
  logic act;

  assign eff_trg = (trg_dly < pre_dly) ? pre_dly : trg_dly;
  assign act     = glob_en & ch_en & running;
  assign pre_o   = act && (cnt == pre_dly);
  assign trg_o   = act && (cnt == eff_trg);

  // R3: pre-trigger is a single-cycle pulse
  assert_pre_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pre_o |=> !pre_o);

  // R4: trigger is a single-cycle pulse
  assert_trg_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    trg_o |=> !trg_o);

  // R4: trigger never comes before the pre-trigger point
  assert_trg_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
    trg_o |-> (cnt >= pre_dly));
endmodule

// File: rtl/trig_dly_top.sv
module trig_dly_top
  import trig_dly_pkg::*;
#(
  parameter int DLY_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_trig,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [DLY_W-1:0]   wr_data,
  output logic               pre_a,
  output logic               trig_a,
  output logic               pre_b,
  output logic               trig_b
);
  logic [1:0]                   rst_pipe;
  logic                         rst_sync_n;
  logic                         glob_en;
  logic [NUM_CH-1:0]            ch_en;
  logic [SEL_W-1:0]             src_sel;
  logic                         sw_pulse;
  logic [NUM_CH-1:0][DLY_W-1:0] pre_dly;
  logic [NUM_CH-1:0][DLY_W-1:0] trg_dly;
  logic [NUM_CH-1:0][DLY_W-1:0] eff_v;
  logic [NUM_CH-1:0]            pre_v;
  logic [NUM_CH-1:0]            trg_v;
  logic                         start_edge;
  logic                         running;
  logic [DLY_W-1:0]             cnt;
  logic [DLY_W-1:0]             end_val;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  trig_dly_regs #(.DW(DLY_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .glob_en  (glob_en),
    .ch_en    (ch_en),
    .src_sel  (src_sel),
    .sw_pulse (sw_pulse),
    .pre_dly  (pre_dly),
    .trg_dly  (trg_dly)
  );

  trig_dly_src u_src (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .src_trig   (src_trig),
    .sw_pulse   (sw_pulse),
    .src_sel    (src_sel),
    .start_edge (start_edge)
  );

  always_comb begin
    end_val = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (eff_v[c] > end_val) end_val = eff_v[c];
    end
  end

  trig_dly_seq #(.W(DLY_W)) u_seq (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .glob_en (glob_en),
    .start   (start_edge),
    .end_val (end_val),
    .running (running),
    .cnt     (cnt)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    trig_dly_chan #(.W(DLY_W)) u_ch (
      .clk     (clk),
      .rst_n   (rst_sync_n),
      .running (running),
      .cnt     (cnt),
      .pre_dly (pre_dly[g]),
      .trg_dly (trg_dly[g]),
      .glob_en (glob_en),
      .ch_en   (ch_en[g]),
      .pre_o   (pre_v[g]),
      .trg_o   (trg_v[g]),
      .eff_trg (eff_v[g])
    );
  end

  assign pre_a  = pre_v[0];
  assign trig_a = trg_v[0];
  assign pre_b  = pre_v[1];
  assign trig_b = trg_v[1];

  // R10: while reset is held, every output stays low
  assert_reset_quiet_R10: assert property (@(posedge clk)
    !rst_sync_n |-> !(pre_a || trig_a || pre_b || trig_b));
endmodule

// File: tb/trig_dly_top_tb_top.sv
module trig_dly_top_tb_top;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  src_trig;
  logic        wr_en;
  logic [2:0]  wr_addr;
  logic [15:0] wr_data;
  logic        pre_a, trig_a, pre_b, trig_b;

  int total = 0;
  int bad   = 0;
  int sidx;
  int pc [4];
  int pp [4];

  always #(CLK_P / 2) clk = ~clk;

  trig_dly_top dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .src_trig (src_trig),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .pre_a    (pre_a),
    .trig_a   (trig_a),
    .pre_b    (pre_b),
    .trig_b   (trig_b)
  );

  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic int ctl(input int gen, input int ea, input int eb,
                             input int sel, input int sw);
    return gen | (ea << 1) | (eb << 2) | (sel << 4) | (sw << 8);
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    wr_en   = 1'b1;
    wr_addr = a[2:0];
    wr_data = d[15:0];
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  task automatic clr();
    sidx = 0;
    for (int j = 0; j < 4; j++) begin
      pc[j] = 0;
      pp[j] = -1;
    end
  endtask

  task automatic obs(input int n);
    logic [3:0] v;
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      @(negedge clk);
      v = {trig_b, pre_b, trig_a, pre_a};
      for (int j = 0; j < 4; j++) begin
        if (v[j]) begin
          if (pc[j] == 0) pp[j] = sidx;
          pc[j]++;
        end
      end
      sidx++;
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // expected first-pulse sample per output; -1 means no pulse
  task automatic expect_run(input string tag, input int e0, input int e1,
                            input int e2, input int e3);
    int e [4];
    e[0] = e0; e[1] = e1; e[2] = e2; e[3] = e3;
    for (int j = 0; j < 4; j++) begin
      if (e[j] < 0) begin
        chk($sformatf("%s out%0d count", tag, j), pc[j], 0);
      end else begin
        chk($sformatf("%s out%0d count", tag, j), pc[j], 1);
        chk($sformatf("%s out%0d pos", tag, j), pp[j], e[j]);
      end
    end
  endtask

  initial begin
    #(CLK_P * 100000);
    total++;
    bad++;
    $display("FAIL watchdog expired act=0 exp=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n    = 1'b0;
    src_trig = 8'h00;
    wr_en    = 1'b0;
    wr_addr  = 3'd0;
    wr_data  = 16'h0000;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R10: outputs low after reset, block disabled
    chk("R10 reset outputs", int'({trig_b, pre_b, trig_a, pre_a}), 0);
    clr();
    src_trig[0] = 1'b1;
    obs(6);
    src_trig = 8'h00;
    idle(2);
    expect_run("R10 R7 disabled after reset", -1, -1, -1, -1);

    // R3 R4 R5: sweep of small delay values, including trigger < pre
    wr(0, ctl(1, 1, 1, 0, 0));
    for (int pa = 0; pa < 4; pa++) begin
      for (int ta = 0; ta < 4; ta++) begin
        int pb;
        int tb;
        pb = 3 - pa;
        tb = (ta + 1) % 4;
        wr(1, pa); wr(2, ta); wr(3, pb); wr(4, tb);
        clr();
        src_trig[0] = 1'b1;
        obs(8);
        src_trig = 8'h00;
        idle(2);
        expect_run($sformatf("R3 R4 R5 sweep pa=%0d ta=%0d", pa, ta),
                   pa, mx(pa, ta), pb, mx(pb, tb));
      end
    end

    // R1 R8: source selection sweep
    wr(1, 1); wr(2, 2); wr(3, 0); wr(4, 0);
    for (int s = 0; s < 8; s++) begin
      wr(0, ctl(1, 1, 1, s, 0));
      clr();
      src_trig = 8'hFF & ~(8'h01 << s);
      obs(6);
      src_trig = 8'h00;
      idle(2);
      expect_run($sformatf("R1 unselected sel=%0d", s), -1, -1, -1, -1);
      if (s == 2) begin
        clr();
        src_trig = 8'hFF;
        obs(6);
        src_trig = 8'h00;
        idle(2);
        expect_run("R8 pin 2 ignored", -1, -1, -1, -1);
        clr();
        wr(0, ctl(1, 1, 1, 2, 1));
        obs(8);
        idle(2);
        expect_run("R8 software trigger", 1, 2, 0, 0);
      end else begin
        clr();
        src_trig[s] = 1'b1;
        obs(8);
        src_trig = 8'h00;
        idle(2);
        expect_run($sformatf("R1 selected sel=%0d", s), 1, 2, 0, 0);
      end
    end

    // R2: level held high gives one pulse per output
    wr(0, ctl(1, 1, 1, 0, 0));
    wr(1, 1); wr(2, 2); wr(3, 0); wr(4, 3);
    clr();
    src_trig[0] = 1'b1;
    obs(12);
    src_trig = 8'h00;
    idle(2);
    expect_run("R2 level hold", 1, 2, 0, 3);

    // R6: edge during run ignored, then a fresh run after the end
    wr(1, 4); wr(2, 5); wr(3, 1); wr(4, 6);
    clr();
    src_trig[0] = 1'b1;
    obs(2);
    src_trig[0] = 1'b0;
    obs(1);
    src_trig[0] = 1'b1;
    obs(9);
    src_trig = 8'h00;
    idle(2);
    expect_run("R6 edge during run", 4, 5, 1, 6);
    clr();
    src_trig[0] = 1'b1;
    obs(8);
    src_trig = 8'h00;
    idle(2);
    expect_run("R6 run after end", 4, 5, 1, 6);

    // R9: channel enables gate outputs only
    wr(0, ctl(1, 0, 1, 0, 0));
    wr(1, 1); wr(2, 2); wr(3, 5); wr(4, 6);
    clr();
    src_trig[0] = 1'b1;
    obs(10);
    src_trig = 8'h00;
    idle(2);
    expect_run("R9 A disabled", -1, -1, 5, 6);
    wr(0, ctl(1, 1, 0, 0, 0));
    wr(1, 2); wr(2, 3);
    clr();
    src_trig[0] = 1'b1;
    obs(10);
    src_trig = 8'h00;
    idle(2);
    expect_run("R9 B disabled", 2, 3, -1, -1);

    // R7: global enable clear aborts; re-enable needs a new edge
    wr(0, ctl(1, 1, 1, 0, 0));
    wr(1, 6); wr(2, 7); wr(3, 6); wr(4, 7);
    clr();
    src_trig[0] = 1'b1;
    obs(3);
    wr(0, ctl(0, 1, 1, 0, 0));
    obs(8);
    wr(0, ctl(1, 1, 1, 0, 0));
    obs(10);
    src_trig = 8'h00;
    idle(2);
    expect_run("R7 abort", -1, -1, -1, -1);
    clr();
    src_trig[0] = 1'b1;
    obs(10);
    src_trig = 8'h00;
    idle(2);
    expect_run("R7 restart", 6, 7, 6, 7);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule